// File: doc/BRIEF.md
# Command/Address Parity Gate

This block sits in the registered command/address path of a memory buffer. Each cycle it captures an address word, a small command field and a set of active-low chip selects. One clock later it receives the parity bit that belongs to that word. It holds the word for one extra stage so that the late parity can be compared before anything is released. A selected word that fails the even-parity test is cancelled: its chip selects leave the block all high, so downstream logic treats the slot as idle. The block then drives an active-low alarm for a fixed number of clocks. Words captured with every select high are never judged.

A word with every select low and a reserved command code is a control write. It carries a 4-bit register index in address bits 3:0 and a 4-bit value in address bits 7:4. It is parity-checked like any other command. When it passes, it updates one of sixteen internal 4-bit control registers and is not forwarded. When it fails, it is discarded and the alarm fires.

Top module: `ca_parity_gate`

## Requirements
- R1: While reset is applied and until the first command is released afterwards, `fwd_cs_n` is all ones, `err_n` is 1 and every control register reads 0.
- R2: A selected word (at least one `ca_cs_n` bit low) that passes parity and is not a control write appears on `fwd_addr`, `fwd_op` and `fwd_cs_n` unchanged after the clock edge that follows its capture edge.
- R3: The word captured on edge n is paired with `ca_par` captured on edge n+1. It passes when the count of ones over `ca_addr`, `ca_op` and that parity bit is even.
- R4: A selected word that fails parity is dropped: in its output slot `fwd_cs_n` is all ones.
- R5: For a word captured on edge n that is selected and fails parity, `err_n` is 0 after edges n+3 and n+4. Without a further error it is 1 again after edge n+5.
- R6: A word captured with all `ca_cs_n` bits high never causes `err_n` to go low, whatever its parity, and its output slot has `fwd_cs_n` all ones.
- R7: A new error while the alarm is active restarts the 2-clock count. Failing words on edges n and n+1 therefore hold `err_n` low after edges n+3, n+4 and n+5.
- R8: Failing words on edges n and n+3, with two clean words between them, give two separate alarm pulses, with `err_n` high after edge n+5.
- R9: A control write is a word with all four `ca_cs_n` bits low and `ca_op` equal to 3'b000. When its parity passes, control register `ca_addr[3:0]` takes `ca_addr[7:4]` on the edge after capture. In its slot `fwd_cs_n` is all ones.
- R10: A control write that fails parity changes no control register, raises the alarm as in R5, and has `fwd_cs_n` all ones in its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ca_addr | input | 14 | Address bits of the incoming word |
| ca_op | input | 3 | Command code bits of the incoming word |
| ca_cs_n | input | 4 | Active-low chip selects of the incoming word |
| ca_par | input | 1 | Even-parity bit for the word captured one clock earlier |
| fwd_addr | output | 14 | Released address |
| fwd_op | output | 3 | Released command code |
| fwd_cs_n | output | 4 | Released chip selects, all ones when the slot is cancelled |
| err_n | output | 1 | Active-low parity alarm |
| ctl_words | output | 64 | Control registers, register i at bits 4i+3:4i |

## Verification
The hardest situations to reach from the ports depend on where errors fall relative to each other. One is two failures exactly three captures apart, which must give two distinct pulses. Another is failures on consecutive cycles, which must merge through the restart. A third is a control write that fails parity, which must leave the register file untouched. Random traffic rarely lands on these spacings, so directed words place them at fixed cycles. A seeded random stream then adds wide mixes of selects, command codes, forced control writes and about one parity failure in six.

// File: rtl/ca_pg_pkg.sv
package ca_pg_pkg;
  localparam int CW_IDX_W = 4;
  localparam int CW_DAT_W = 4;
  localparam int CW_COUNT = 1 << CW_IDX_W;
endpackage

// File: rtl/ca_pg_capture.sv
module ca_pg_capture #(
  parameter int AW  = 14,
  parameter int OPW = 3,
  parameter int NCS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  in_addr,
  input  logic [OPW-1:0] in_op,
  input  logic [NCS-1:0] in_cs_n,
  output logic [AW-1:0]  s1_addr,
  output logic [OPW-1:0] s1_op,
  output logic [NCS-1:0] s1_cs_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_addr <= '0;
      s1_op   <= '0;
      s1_cs_n <= '1;
    end else begin
      s1_addr <= in_addr;
      s1_op   <= in_op;
      s1_cs_n <= in_cs_n;
    end
  end
endmodule

// File: rtl/ca_pg_judge.sv
module ca_pg_judge #(
  parameter int             AW    = 14,
  parameter int             OPW   = 3,
  parameter int             NCS   = 4,
  parameter logic [OPW-1:0] CW_OP = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  s1_addr,
  input  logic [OPW-1:0] s1_op,
  input  logic [NCS-1:0] s1_cs_n,
  input  logic           late_par,
  output logic [AW-1:0]  fwd_addr,
  output logic [OPW-1:0] fwd_op,
  output logic [NCS-1:0] fwd_cs_n,
  output logic           bad_hit,
  output logic           cw_we
);
  logic           any_sel, all_sel, is_cw, odd, bad;
  logic [NCS-1:0] cs_d;

  always_comb begin
    any_sel = ~&s1_cs_n;
    all_sel = ~|s1_cs_n;
    is_cw   = all_sel && (s1_op == CW_OP);
    odd     = ^{s1_addr, s1_op, late_par};
    bad     = any_sel && odd;
    cw_we   = is_cw && !odd;
    cs_d    = (bad || is_cw) ? '1 : s1_cs_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_addr <= '0;
      fwd_op   <= '0;
      fwd_cs_n <= '1;
      bad_hit  <= 1'b0;
    end else begin
      fwd_addr <= s1_addr;
      fwd_op   <= s1_op;
      fwd_cs_n <= cs_d;
      bad_hit  <= bad;
    end
  end
endmodule

// File: rtl/ca_pg_alert.sv
module ca_pg_alert #(
  parameter int ERR_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bad_hit,
  output logic err_n
);
  localparam int CNTW = $clog2(ERR_CLKS + 1);

  logic            bad_d;
  logic [CNTW-1:0] cnt, cnt_d;

  always_comb begin
    if (bad_d)            cnt_d = CNTW'(ERR_CLKS);
    else if (cnt != '0)   cnt_d = cnt - CNTW'(1);
    else                  cnt_d = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_d <= 1'b0;
      cnt   <= '0;
    end else begin
      bad_d <= bad_hit;
      cnt   <= cnt_d;
    end
  end

  assign err_n = (cnt == '0);
endmodule

// File: rtl/ca_pg_ctlfile.sv
module ca_pg_ctlfile
  import ca_pg_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [CW_IDX_W-1:0]          idx,
  input  logic [CW_DAT_W-1:0]          dat,
  output logic [CW_COUNT*CW_DAT_W-1:0] words
);
  for (genvar i = 0; i < CW_COUNT; i++) begin : g_cw
    logic [CW_DAT_W-1:0] r;
    logic                en;
    assign en = we && (idx == CW_IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  r <= '0;
      else if (en) r <= dat;
    end
    assign words[i*CW_DAT_W +: CW_DAT_W] = r;
  end
endmodule

// File: rtl/ca_parity_gate.sv
module ca_parity_gate
  import ca_pg_pkg::*;
#(
  parameter int             AW       = 14,
  parameter int             OPW      = 3,
  parameter int             NCS      = 4,
  parameter int             ERR_CLKS = 2,
  parameter logic [OPW-1:0] CW_OP    = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [AW-1:0]                ca_addr,
  input  logic [OPW-1:0]               ca_op,
  input  logic [NCS-1:0]               ca_cs_n,
  input  logic                         ca_par,
  output logic [AW-1:0]                fwd_addr,
  output logic [OPW-1:0]               fwd_op,
  output logic [NCS-1:0]               fwd_cs_n,
  output logic                         err_n,
  output logic [CW_COUNT*CW_DAT_W-1:0] ctl_words
);
  localparam int DAT_LO = CW_IDX_W;

  logic           rst_m_n, rst_q_n;
  logic [AW-1:0]  s1_addr;
  logic [OPW-1:0] s1_op;
  logic [NCS-1:0] s1_cs_n;
  logic           bad_hit, cw_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_n <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_m_n <= 1'b1;
      rst_q_n <= rst_m_n;
    end
  end

  ca_pg_capture #(.AW(AW), .OPW(OPW), .NCS(NCS)) u_cap (
    .clk(clk), .rst_n(rst_q_n),
    .in_addr(ca_addr), .in_op(ca_op), .in_cs_n(ca_cs_n),
    .s1_addr(s1_addr), .s1_op(s1_op), .s1_cs_n(s1_cs_n)
  );

  ca_pg_judge #(.AW(AW), .OPW(OPW), .NCS(NCS), .CW_OP(CW_OP)) u_judge (
    .clk(clk), .rst_n(rst_q_n),
    .s1_addr(s1_addr), .s1_op(s1_op), .s1_cs_n(s1_cs_n), .late_par(ca_par),
    .fwd_addr(fwd_addr), .fwd_op(fwd_op), .fwd_cs_n(fwd_cs_n),
    .bad_hit(bad_hit), .cw_we(cw_we)
  );

  ca_pg_alert #(.ERR_CLKS(ERR_CLKS)) u_alert (
    .clk(clk), .rst_n(rst_q_n), .bad_hit(bad_hit), .err_n(err_n)
  );

  ca_pg_ctlfile u_ctl (
    .clk(clk), .rst_n(rst_q_n), .we(cw_we),
    .idx(s1_addr[CW_IDX_W-1:0]),
    .dat(s1_addr[DAT_LO +: CW_DAT_W]),
    .words(ctl_words)
  );
endmodule

// File: rtl/ca_pg_checker.sv
module ca_pg_checker #(
  parameter int             AW    = 14,
  parameter int             OPW   = 3,
  parameter int             NCS   = 4,
  parameter int             CWW   = 64,
  parameter logic [OPW-1:0] CW_OP = '0
) (
  input logic           clk,
  input logic           rst_q_n,
  input logic [AW-1:0]  ca_addr,
  input logic [OPW-1:0] ca_op,
  input logic [NCS-1:0] ca_cs_n,
  input logic           ca_par,
  input logic [AW-1:0]  fwd_addr,
  input logic [NCS-1:0] fwd_cs_n,
  input logic           err_n,
  input logic [CWW-1:0] ctl_words,
  input logic           bad_hit
);
  logic [1:0] age;
  logic       arm;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)        age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign arm = (age == 2'd3);

  assert_pass_R2: assert property (@(posedge clk) disable iff (!arm)
    (!(&$past(ca_cs_n, 2)) && !(^{$past(ca_addr, 2), $past(ca_op, 2), $past(ca_par)})
     && !((~|$past(ca_cs_n, 2)) && ($past(ca_op, 2) == CW_OP)))
    |-> (fwd_cs_n == $past(ca_cs_n, 2) && fwd_addr == $past(ca_addr, 2)));

  assert_drop_R4: assert property (@(posedge clk) disable iff (!arm)
    (!(&$past(ca_cs_n, 2)) && (^{$past(ca_addr, 2), $past(ca_op, 2), $past(ca_par)}))
    |-> (&fwd_cs_n));

  assert_desel_R6: assert property (@(posedge clk) disable iff (!arm)
    (&$past(ca_cs_n, 2)) |-> !bad_hit);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!arm)
    bad_hit |-> (ctl_words == $past(ctl_words)));

  assert_pulse_R5: assert property (@(posedge clk) disable iff (!arm)
    $fell(err_n) |-> ($past(bad_hit, 2) ##1 !err_n));
endmodule

bind ca_parity_gate ca_pg_checker #(
  .AW(AW), .OPW(OPW), .NCS(NCS), .CWW(ca_pg_pkg::CW_COUNT * ca_pg_pkg::CW_DAT_W), .CW_OP(CW_OP)
) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .ca_addr(ca_addr), .ca_op(ca_op), .ca_cs_n(ca_cs_n),
  .ca_par(ca_par), .fwd_addr(fwd_addr), .fwd_cs_n(fwd_cs_n), .err_n(err_n),
  .ctl_words(ctl_words), .bad_hit(bad_hit)
);

// File: tb/tb_ca_parity_gate.sv
`timescale 1ns/1ps
module tb_ca_parity_gate;
  localparam int NW = 2000;
  localparam int NA = NW + 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] ca_addr;
  logic [2:0]  ca_op;
  logic [3:0]  ca_cs_n;
  logic        ca_par;
  logic [13:0] fwd_addr;
  logic [2:0]  fwd_op;
  logic [3:0]  fwd_cs_n;
  logic        err_n;
  logic [63:0] ctl_words;

  ca_parity_gate dut (
    .clk(clk), .rst_n(rst_n), .ca_addr(ca_addr), .ca_op(ca_op), .ca_cs_n(ca_cs_n),
    .ca_par(ca_par), .fwd_addr(fwd_addr), .fwd_op(fwd_op), .fwd_cs_n(fwd_cs_n),
    .err_n(err_n), .ctl_words(ctl_words)
  );

  always #4 clk = ~clk;

  logic [13:0] wa [NA];
  logic [2:0]  wo [NA];
  logic [3:0]  wc [NA];
  logic        wbad [NA];
  logic        pb [NA];
  logic [3:0]  cm [16];
  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  function automatic bit is_ctl(int w);
    return (wc[w] == 4'b0000) && (wo[w] == 3'b000);
  endfunction
  function automatic bit is_err(int w);
    return (wc[w] != 4'b1111) && wbad[w];
  endfunction
  function automatic logic [3:0] exp_cs(int w);
    return (is_err(w) || is_ctl(w)) ? 4'b1111 : wc[w];
  endfunction
  function automatic bit exp_err_low(int e);
    return (e >= 3 && is_err(e - 3)) || (e >= 4 && is_err(e - 4));
  endfunction
  function automatic logic [63:0] model_flat();
    logic [63:0] f;
    for (int i = 0; i < 16; i++) f[i*4 +: 4] = cm[i];
    return f;
  endfunction

  task automatic put(int t, logic [3:0] cs, logic [2:0] op, logic [13:0] a, bit bad);
    wc[t] = cs; wo[t] = op; wa[t] = a; wbad[t] = bad;
    pb[t] = (^{a, op}) ^ bad;
  endtask

  task automatic cmp(string tag, logic [63:0] got, logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_edge(int e);
    int w;
    string tg;
    w = e - 1;
    if (is_ctl(w) && !is_err(w)) cm[wa[w][3:0]] = wa[w][7:4];
    if (is_err(w))            tg = "R3/R4 fwd_cs_n";
    else if (is_ctl(w))       tg = "R9/R10 fwd_cs_n";
    else if (wc[w] == 4'hF)   tg = "R6 fwd_cs_n";
    else                      tg = "R2 fwd_cs_n";
    cmp(tg, 64'(fwd_cs_n), 64'(exp_cs(w)));
    if (exp_cs(w) != 4'hF) begin
      cmp("R2 fwd_addr", 64'(fwd_addr), 64'(wa[w]));
      cmp("R2 fwd_op", 64'(fwd_op), 64'(wo[w]));
    end
    if (e >= 13 && e <= 18)      tg = "R8 err_n";
    else if (e >= 23 && e <= 26) tg = "R7 err_n";
    else if (e >= 4 && e <= 8)   tg = "R5/R6 err_n";
    else                         tg = "R5 err_n";
    cmp(tg, 64'(err_n), 64'(!exp_err_low(e)));
    cmp("R9/R10 ctl_words", ctl_words, model_flat());
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int t = 0; t < NA; t++) put(t, 4'hF, 3'b001, 14'h0, 1'b0);
    for (int t = 40; t < NW; t++) begin
      logic [3:0] cs;
      logic [2:0] op;
      cs = 4'($urandom);
      op = 3'($urandom);
      if ($urandom % 4 == 0) cs = 4'hF;
      if ($urandom % 8 == 0) begin cs = 4'h0; op = 3'b000; end
      put(t, cs, op, 14'($urandom), ($urandom % 6) == 0);
    end
    put(0, 4'b1110, 3'b101, 14'h1234, 1'b0);
    put(1, 4'b1101, 3'b011, 14'h0F0F, 1'b1);   // R4
    put(2, 4'b1111, 3'b010, 14'h0333, 1'b1);   // R6
    put(3, 4'b0111, 3'b110, 14'h2AAA, 1'b0);   // R3
    put(10, 4'b1011, 3'b100, 14'h0011, 1'b1);  // R8 first
    put(11, 4'b1110, 3'b100, 14'h0022, 1'b0);
    put(12, 4'b1110, 3'b111, 14'h0044, 1'b0);
    put(13, 4'b0111, 3'b100, 14'h0088, 1'b1);  // R8 second
    put(20, 4'b1110, 3'b001, 14'h1111, 1'b1);  // R7
    put(21, 4'b1101, 3'b010, 14'h2222, 1'b1);
    put(30, 4'b0000, 3'b000, 14'h00A5, 1'b0);  // R9
    put(31, 4'b0000, 3'b000, 14'h0035, 1'b1);  // R10
    put(32, 4'b0000, 3'b000, 14'h00FF, 1'b0);  // R9
    for (int i = 0; i < 16; i++) cm[i] = 4'h0;

    rst_n = 1'b0; ca_addr = '0; ca_op = '0; ca_cs_n = 4'hF; ca_par = 1'b0;
    repeat (3) @(negedge clk);
    cmp("R1 fwd_cs_n", 64'(fwd_cs_n), 64'hF);
    cmp("R1 err_n", 64'(err_n), 64'h1);
    cmp("R1 ctl_words", ctl_words, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp("R1 fwd_cs_n idle", 64'(fwd_cs_n), 64'hF);
    cmp("R1 err_n idle", 64'(err_n), 64'h1);

    for (int t = 0; t <= NW + 5; t++) begin
      if (t > 0) begin
        @(negedge clk);
        check_edge(t - 1);
      end
      ca_addr = wa[t]; ca_op = wo[t]; ca_cs_n = wc[t];
      ca_par  = (t > 0) ? pb[t-1] : 1'b0;
    end
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule